// File: doc/BRIEF.md
# Parallel Code-Flash Programming Controller

This block models the parallel programming port of a small on-chip code flash. An external programmer selects an operation with four mode pins and presents a 12-bit address and a data byte. Each operation is started by an active-low program strobe. Byte writes, lock-bit programming and chip erase are self-timed: the ready output stays low until a write counter has finished. Reads are combinational on the data port. Verify reads return the stored byte. Signature reads return fixed identification bytes.

The array is a register array of 2^MEM_AW bytes indexed by the low address bits. A write can only clear bits; only a chip erase returns bits to one. Three lock bits restrict what the port may do. They cannot be read back. A logical enable input, `prog_en`, stands in for the programming-voltage detection.

Top module: `flash_prog_ctrl`

## Requirements
- R1: The operation is decoded from `mode_pins[3:0]`, with 1 meaning high. The codes are: 4'b0111 write byte, 4'b0011 verify read, 4'b0000 signature read, 4'b1000 chip erase, 4'b1111 lock bit 1, 4'b1100 lock bit 2, 4'b1010 lock bit 3.
- R2: After reset, `ready` is 1, all lock bits are clear and every byte reads FFh in verify mode.
- R3: Address, data and mode are captured on the clock edge where `prog_n` is first seen low. On the edge where `prog_n` is first seen high again, an accepted operation drives `ready` low from the next cycle for exactly WRITE_CYC cycles.
- R4: A byte write stores the bitwise AND of the old byte and the data, so a write can only clear bits.
- R5: While a byte write is busy, a verify read of the same address returns the complement of the written data bit 7 on `dout[7]`. Bits 6:0 return the stored byte. After `ready` returns high, the true byte is returned.
- R6: Signature reads return 1Eh at 030h, 51h at 031h, and at 032h FFh when SIG_HV=1 or 05h when SIG_HV=0. Every other address returns 00h. Signature reads work whatever the lock state.
- R7: Once lock bit 1 is set, a byte-write strobe changes no byte and leaves `ready` high.
- R8: With lock bits 1 and 2 both set, a verify read leaves `dout_oe` at 0 and `dout` at 00h.
- R9: A chip erase is accepted only if `prog_n` was sampled low for at least ERASE_CYC cycles. It then sets every byte to FFh, clears all lock bits and goes busy like a write. A shorter erase strobe is ignored.
- R10: Strobes that begin while `ready` is low are ignored.
- R11: `dout_oe` is 1 only when `prog_en`=1, `prog_n`=1 and the mode is verify or signature. Otherwise `dout` is 00h. Strobes are ignored while `prog_en`=0.
- R12: Addresses that differ only above bit MEM_AW-1 select the same array byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Programming-port enable |
| prog_n | input | 1 | Active-low program strobe |
| mode_pins | input | 4 | Operation select |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Data port driven |
| ready | output | 1 | High when idle, low while an operation is timing |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that mode, address and data are held stable while `prog_n` is low. The bench meets this by changing inputs only on falling clock edges and by holding them across every strobe. Each strobe lasts at least two cycles, except the deliberately short and deliberately late strobes used for the ignore cases. Randomized writes use random upper address bits over a small low-address pool. This makes repeated AND-merges and aliasing likely.

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
  parameter int ADDR_W    = 12,
  parameter int MEM_AW    = 8,
  parameter int WRITE_CYC = 16,
  parameter int ERASE_CYC = 40,
  parameter bit SIG_HV    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              prog_n,
  input  logic [3:0]        mode_pins,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe,
  output logic              ready
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int WCW   = $clog2(WRITE_CYC + 1);
  localparam int ECW   = $clog2(ERASE_CYC + 1);

  localparam logic [3:0] M_WRITE = 4'b0111;
  localparam logic [3:0] M_READ  = 4'b0011;
  localparam logic [3:0] M_SIG   = 4'b0000;
  localparam logic [3:0] M_ERASE = 4'b1000;
  localparam logic [3:0] M_LB1   = 4'b1111;
  localparam logic [3:0] M_LB2   = 4'b1100;
  localparam logic [3:0] M_LB3   = 4'b1010;

  logic [7:0]        mem [DEPTH];
  logic              prog_q, armed, busy;
  logic [WCW-1:0]    wcnt;
  logic [ECW-1:0]    lcnt;
  logic [3:0]        lat_mode;
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0]        lat_data;
  logic [2:0]        lock;
  logic              poll_vld, poll_b7;
  logic [ADDR_W-1:0] poll_addr;

  wire fall     = prog_en & ~prog_n & prog_q & ~busy;
  wire rise     = prog_en & prog_n & ~prog_q & armed;
  wire do_write = rise && lat_mode == M_WRITE && !lock[0];
  wire do_lock  = rise && (lat_mode == M_LB1 || lat_mode == M_LB2 || lat_mode == M_LB3);
  wire do_erase = rise && lat_mode == M_ERASE && lcnt >= ECW'(ERASE_CYC);
  wire start    = do_write | do_lock | do_erase;
  wire [MEM_AW-1:0] lat_idx = lat_addr[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q   <= 1'b1;
      armed    <= 1'b0;
      lcnt     <= '0;
      lat_mode <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      prog_q <= prog_n;
      if (!prog_n) begin
        if (lcnt != '1) lcnt <= lcnt + 1'b1;
      end else begin
        lcnt <= '0;
      end
      if (fall) begin
        armed    <= 1'b1;
        lat_mode <= mode_pins;
        lat_addr <= addr;
        lat_data <= din;
      end else if (prog_n && !prog_q) begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wcnt      <= '0;
      poll_vld  <= 1'b0;
      poll_b7   <= 1'b0;
      poll_addr <= '0;
      lock      <= '0;
    end else begin
      if (start) begin
        busy <= 1'b1;
        wcnt <= WCW'(WRITE_CYC - 1);
      end else if (busy) begin
        if (wcnt == '0) busy <= 1'b0;
        else wcnt <= wcnt - 1'b1;
      end
      if (do_write) begin
        poll_vld  <= 1'b1;
        poll_b7   <= lat_data[7];
        poll_addr <= lat_addr;
      end else if (start || (busy && wcnt == '0)) begin
        poll_vld <= 1'b0;
      end
      if (do_erase) lock <= '0;
      else if (do_lock) begin
        if (lat_mode == M_LB1) lock[0] <= 1'b1;
        if (lat_mode == M_LB2) lock[1] <= 1'b1;
        if (lat_mode == M_LB3) lock[2] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (do_erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (do_write) begin
      mem[lat_idx] <= mem[lat_idx] & lat_data;
    end
  end

  logic [7:0] sig_byte;
  always_comb begin
    case (addr)
      ADDR_W'(12'h030): sig_byte = 8'h1E;
      ADDR_W'(12'h031): sig_byte = 8'h51;
      ADDR_W'(12'h032): sig_byte = SIG_HV ? 8'hFF : 8'h05;
      default:          sig_byte = 8'h00;
    endcase
  end

  wire        is_read  = mode_pins == M_READ;
  wire        is_sig   = mode_pins == M_SIG;
  wire [7:0]  rd_word  = mem[addr[MEM_AW-1:0]];
  wire        poll_hit = poll_vld && addr == poll_addr;
  wire        rd_ok    = prog_en & prog_n & (is_sig | (is_read & ~(lock[0] & lock[1])));

  assign dout_oe = rd_ok;
  assign dout    = !rd_ok   ? 8'h00 :
                   is_sig   ? sig_byte :
                   poll_hit ? {~poll_b7, rd_word[6:0]} : rd_word;
  assign ready   = ~busy;
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        mode_pins,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dout,
  input logic              dout_oe,
  input logic              ready,
  input logic              start,
  input logic              rise,
  input logic [3:0]        lat_mode,
  input logic [2:0]        lock,
  input logic              poll_vld,
  input logic              poll_b7,
  input logic [ADDR_W-1:0] poll_addr
);
  int unsigned bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= 0;
    else if (ready) bcnt <= 0;
    else bcnt <= bcnt + 1;
  end

  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready); // R3
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> bcnt < WRITE_CYC); // R3
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && bcnt == WRITE_CYC - 1) |=> ready); // R3
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && lat_mode == 4'b0111 && lock[0]) |=> ready); // R7
  AST_SIG_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && mode_pins == 4'b0000 && addr == ADDR_W'(12'h030)) |-> dout == 8'h1E); // R6
  AST_POLL_B7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_vld && dout_oe && mode_pins == 4'b0011 && addr == poll_addr) |-> dout[7] == ~poll_b7); // R5
  AST_VERIFY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock[0] && lock[1] && mode_pins == 4'b0011) |-> !dout_oe); // R8
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == 8'h00); // R11
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .addr(addr), .dout(dout),
  .dout_oe(dout_oe), .ready(ready), .start(start), .rise(rise), .lat_mode(lat_mode),
  .lock(lock), .poll_vld(poll_vld), .poll_b7(poll_b7), .poll_addr(poll_addr)
);

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WC = 12;
  localparam int EC = 30;
  localparam logic [3:0] M_WRITE = 4'b0111, M_READ = 4'b0011, M_SIG = 4'b0000,
                         M_ERASE = 4'b1000, M_LB1 = 4'b1111, M_LB2 = 4'b1100, M_LB3 = 4'b1010;

  logic clk = 0, rst_n = 0, prog_en = 1, prog_n = 1;
  logic [3:0] mode_pins = M_READ;
  logic [11:0] addr = 0;
  logic [7:0] din = 0, dout;
  logic dout_oe, ready;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] ref_mem [256];
  logic [2:0] rlk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(12), .MEM_AW(8), .WRITE_CYC(WC), .ERASE_CYC(EC), .SIG_HV(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_n(prog_n), .mode_pins(mode_pins),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .ready(ready));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_rd(logic [3:0] m, logic [11:0] a);
    if (m == M_SIG) begin
      case (a)
        12'h030: return {1'b1, 8'h1E};
        12'h031: return {1'b1, 8'h51};
        12'h032: return {1'b1, 8'hFF};
        default: return {1'b1, 8'h00};
      endcase
    end
    if (m == M_READ && !(rlk[0] && rlk[1])) return {1'b1, ref_mem[a[7:0]]};
    return 9'h000;
  endfunction

  task automatic rd_chk(string req, logic [3:0] m, logic [11:0] a);
    @(negedge clk); mode_pins = m; addr = a; #1;
    chk(req, {dout_oe, dout}, exp_rd(m, a));
  endtask

  task automatic pulse(logic [3:0] m, logic [11:0] a, logic [7:0] d, int low);
    @(negedge clk); mode_pins = m; addr = a; din = d; prog_n = 0;
    repeat (low) @(negedge clk);
    prog_n = 1;
  endtask

  task automatic op(string req, logic [3:0] m, logic [11:0] a, logic [7:0] d, int low);
    bit st = 0;
    int n;
    if (m == M_WRITE && !rlk[0]) begin ref_mem[a[7:0]] &= d; st = 1; end
    if (m == M_LB1) begin rlk[0] = 1; st = 1; end
    if (m == M_LB2) begin rlk[1] = 1; st = 1; end
    if (m == M_LB3) begin rlk[2] = 1; st = 1; end
    if (m == M_ERASE && low >= EC) begin
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
      rlk = 0; st = 1;
    end
    pulse(m, a, d, low);
    @(negedge clk); #1;
    chk({req, " R1 ready after strobe"}, ready, !st);
    if (st) begin
      if (m == M_WRITE) begin
        mode_pins = M_READ; #1;
        chk("R5 polling", {dout_oe, dout}, {1'b1, ~d[7], ref_mem[a[7:0]][6:0]});
      end
      n = 1;
      for (int k = 0; k < 4 * WC; k++) begin
        @(negedge clk); #1;
        if (ready) break;
        n++;
      end
      chk("R3 busy length", n, WC);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] ra;
    logic [7:0] rd;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R2 ready after reset", ready, 1);
    rd_chk("R2 erased", M_READ, 12'h000);
    rd_chk("R2 erased", M_READ, 12'hFFF);
    rd_chk("R2 erased", M_READ, 12'h030);

    op("R3", M_WRITE, 12'h005, 8'hA5, 2);
    rd_chk("R3 write", M_READ, 12'h005);
    op("R4", M_WRITE, 12'h005, 8'h0F, 3);
    rd_chk("R4 and-merge", M_READ, 12'h005);
    chk("R4 value", ref_mem[5], 8'h05);
    op("R4", M_WRITE, 12'h005, 8'hFF, 2);
    rd_chk("R4 ones kept cleared", M_READ, 12'h005);

    rd_chk("R6 sig", M_SIG, 12'h030);
    rd_chk("R6 sig", M_SIG, 12'h031);
    rd_chk("R6 sig", M_SIG, 12'h032);
    rd_chk("R6 sig other", M_SIG, 12'h033);

    for (int it = 0; it < 60; it++) begin
      ra = {4'($urandom), 3'b000, 5'($urandom_range(0, 15))};
      rd = 8'($urandom);
      op("R4", M_WRITE, ra, rd, 2 + int'($urandom_range(0, 2)));
      rd_chk("R4 random", M_READ, ra);
      rd_chk("R12 alias", M_READ, {4'($urandom), ra[7:0]});
    end

    op("R9", M_ERASE, 12'h000, 8'h00, 5);
    rd_chk("R9 short erase ignored", M_READ, 12'h005);

    pulse(M_WRITE, 12'h040, 8'h3C, 2);
    ref_mem[8'h40] &= 8'h3C;
    @(negedge clk);
    pulse(M_WRITE, 12'h041, 8'h00, 2);
    @(negedge clk); #1;
    chk("R10 still busy", ready, 0);
    for (int k = 0; k < 4 * WC && !ready; k++) @(negedge clk);
    @(negedge clk); #1;
    chk("R10 no restart", ready, 1);
    rd_chk("R10 ignored byte", M_READ, 12'h041);
    rd_chk("R10 first byte", M_READ, 12'h040);

    @(negedge clk); prog_en = 0;
    pulse(M_WRITE, 12'h042, 8'h00, 2);
    @(negedge clk); #1;
    chk("R11 disabled strobe", ready, 1);
    mode_pins = M_READ; addr = 12'h005; #1;
    chk("R11 oe off", {dout_oe, dout}, 9'h000);
    @(negedge clk); prog_en = 1;
    rd_chk("R11 no write", M_READ, 12'h042);
    @(negedge clk); mode_pins = M_WRITE; #1;
    chk("R11 oe in write mode", {dout_oe, dout}, 9'h000);

    op("R7", M_LB1, 12'h000, 8'h00, 2);
    op("R7", M_WRITE, 12'h005, 8'h00, 2);
    rd_chk("R7 locked write", M_READ, 12'h005);
    op("R8", M_LB2, 12'h000, 8'h00, 2);
    rd_chk("R8 verify blocked", M_READ, 12'h005);
    rd_chk("R6 sig under lock", M_SIG, 12'h031);
    op("R8", M_LB3, 12'h000, 8'h00, 2);

    op("R9", M_ERASE, 12'h000, 8'h00, EC + 2);
    rd_chk("R9 erased", M_READ, 12'h005);
    rd_chk("R9 erased", M_READ, 12'h040);
    op("R9", M_WRITE, 12'h007, 8'h81, 2);
    rd_chk("R9 write after erase", M_READ, 12'h007);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule